// File: doc/BRIEF.md
# Temperature Limit Status and Alert

This block watches the stream of temperature conversion results for two channels, a local sensor and a remote diode. It checks each result against a programmable high and low limit for its channel, and it keeps the outcome in a status byte that a host reads through a bus front end. Each temperature flag stays set until the host reads it. A flag that a result raises is held in a pending register. It shows in the status byte only when the serial bus goes idle, that is, on the first bus clock edge after a stop condition. As a result, a host read never races a flag that is being updated.

A status read may land in the same cycle as an internal update: a conversion result, a conversion start or the post-stop reload. Such a read returns a marker byte and changes no state, and the host reads again. The open-diode fault bit samples the converter's fault signal only when a conversion starts. A separate interrupt latch drives the active-low alert output. It is set when any temperature flag newly becomes set, and it is cleared only by an acknowledge input, so status reads never touch it.

Top module: `temp_limit_status`

## Requirements
- R1: Results and limits are two's complement. A result strictly above its channel's high limit sets that channel's high flag, and a result strictly below its low limit sets the low flag. The status byte bits are: bit 6 local high, bit 5 local low, bit 4 remote high, bit 3 remote low, bit 2 open diode, bits 1:0 zero. `res_chan` 0 selects the local channel and 1 selects the remote channel.
- R2: After reset the status reads 00h and `alert_n` is released. The high limits reset to the largest positive code and the low limits to the most negative code, so no result can raise a flag before the limits are written. `lim_wr_sel` encodes 0 local high, 1 local low, 2 remote high, 3 remote low.
- R3: A temperature flag stays set until a non-colliding status read has reported it, and that read clears it. A later in-range result does not clear it.
- R4: The four temperature bits of the status byte are reloaded from the pending flags only on the first `bus_clk_edge` after a `bus_stop` strobe. Before that reload a read does not show the new flag.
- R5: A read in a cycle that also has `res_valid`, `conv_start` or a post-stop reload returns bits 6:0 all ones. It clears nothing, so the flags appear on the next proper read.
- R6: The open-diode bit takes the value of `diode_open` only in a cycle with `conv_start`. Status reads do not clear it.
- R7: If a limit pair overlaps, one result can set both the high flag and the low flag of its channel.
- R8: `alert_n` goes low one cycle after a result sets a flag that was not already pending. `alert_clr` releases it, and a flag set in the same cycle as `alert_clr` wins.
- R9: Status reads, including colliding ones, never change `alert_n`.
- R10: Bit 7 of read data mirrors `busy` in the cycle of the read. `stat_data` updates one cycle after `stat_rd` and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_wr_en | input | 1 | Limit register write strobe |
| lim_wr_sel | input | 2 | Limit select (0 LH, 1 LL, 2 RH, 3 RL) |
| lim_wr_data | input | TW | Limit value, two's complement |
| res_valid | input | 1 | Conversion result valid |
| res_chan | input | 1 | Result channel, 0 local, 1 remote |
| res_data | input | TW | Result, two's complement degrees |
| conv_start | input | 1 | Conversion start strobe |
| diode_open | input | 1 | Diode open-circuit fault level |
| busy | input | 1 | Converter busy level |
| bus_stop | input | 1 | Bus stop condition strobe |
| bus_clk_edge | input | 1 | Bus clock edge strobe |
| stat_rd | input | 1 | Status read strobe |
| stat_data | output | 8 | Status read data |
| alert_clr | input | 1 | Alert acknowledge |
| alert_n | output | 1 | Alert, active low |

## Verification
Inputs are driven on the falling edge, and each result is due at a fixed number of rising edges. `alert_n` falls one edge after the result is sampled. `stat_data` settles one edge after `stat_rd`. A pending flag reaches the status byte on the edge that samples `bus_clk_edge`, which is two edges after a `bus_stop` strobe. The bench samples every output on the falling edge that follows the edge where that output is due. A table of single-result vectors checks limit compares on both channels, and directed sequences check reload timing, collisions, the open bit, busy and alert priority.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
  localparam int STAT_W = 8;
  localparam int NFLAG  = 4;
  localparam logic [6:0] COLL_MARK = 7'h7F;
  typedef enum logic [1:0] {
    SEL_LHI = 2'd0,
    SEL_LLO = 2'd1,
    SEL_RHI = 2'd2,
    SEL_RLO = 2'd3
  } lim_sel_e;
endpackage

// File: rtl/tstat_limits.sv
module tstat_limits #(
  parameter int TW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [TW-1:0]              wr_data,
  input  logic                       res_valid,
  input  logic                       res_chan,
  input  logic [TW-1:0]              res_data,
  output logic [tstat_pkg::NFLAG-1:0] hit
);
  import tstat_pkg::*;
  localparam logic [TW-1:0] LIM_MAX = {1'b0, {(TW-1){1'b1}}};
  localparam logic [TW-1:0] LIM_MIN = {1'b1, {(TW-1){1'b0}}};

  // index 3 local high, 2 local low, 1 remote high, 0 remote low
  logic [TW-1:0] lim_q [NFLAG];
  logic [TW-1:0] lim_d [NFLAG];

  always_comb begin
    for (int i = 0; i < NFLAG; i++) lim_d[i] = lim_q[i];
    if (wr_en) lim_d[2'd3 - wr_sel] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLAG; i++) lim_q[i] <= (i % 2 == 1) ? LIM_MAX : LIM_MIN;
    end else if (wr_en) begin
      for (int i = 0; i < NFLAG; i++) lim_q[i] <= lim_d[i];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic sel;
    assign sel = res_valid && (res_chan == g[0]);
    assign hit[3-2*g] = sel && ($signed(res_data) > $signed(lim_q[3-2*g]));
    assign hit[2-2*g] = sel && ($signed(res_data) < $signed(lim_q[2-2*g]));
  end

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (hit == '0));
endmodule

// File: rtl/tstat_flags.sv
module tstat_flags (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [tstat_pkg::NFLAG-1:0] hit,
  input  logic                        res_valid,
  input  logic                        conv_start,
  input  logic                        diode_open,
  input  logic                        busy,
  input  logic                        bus_stop,
  input  logic                        bus_clk_edge,
  input  logic                        rd_en,
  output logic [tstat_pkg::STAT_W-1:0] rd_data,
  output logic                        new_flag
);
  import tstat_pkg::*;

  logic [NFLAG-1:0]  pend_q, pend_d, stat_q, stat_d;
  logic              arm_q, arm_d, open_q, open_d;
  logic [STAT_W-1:0] rd_q, rd_d;
  logic              commit, coll, rd_ok;

  always_comb begin
    commit   = arm_q && bus_clk_edge;
    coll     = res_valid || conv_start || commit;
    rd_ok    = rd_en && !coll;
    new_flag = |(hit & ~pend_q);
    arm_d    = bus_stop || (arm_q && !bus_clk_edge);
    pend_d   = rd_ok ? ((pend_q & ~stat_q) | hit) : (pend_q | hit);
    if (commit)     stat_d = pend_q;
    else if (rd_ok) stat_d = '0;
    else            stat_d = stat_q;
    open_d   = conv_start ? diode_open : open_q;
    if (!rd_en)     rd_d = rd_q;
    else if (coll)  rd_d = {busy, COLL_MARK};
    else            rd_d = {busy, stat_q, open_q, 2'b00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
      arm_q  <= 1'b0;
      open_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      stat_q <= stat_d;
      arm_q  <= arm_d;
      if (conv_start) open_q <= open_d;
      if (rd_en)      rd_q   <= rd_d;
    end
  end

  assign rd_data = rd_q;

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  p_hold_until_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !rd_ok) |=> $stable(stat_q));
  p_marker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && coll) |=> (rd_data[6:0] == COLL_MARK));
  p_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> $stable(open_q));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/tstat_alert.sv
module tstat_alert (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic alert_n
);
  logic latch_q, latch_d;

  always_comb latch_d = set_i || (latch_q && !clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end

  assign alert_n = !latch_q;

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !alert_n);
  p_only_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> !$fell(alert_n));
endmodule

// File: rtl/temp_limit_status.sv
module temp_limit_status #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_wr_en,
  input  logic [1:0]    lim_wr_sel,
  input  logic [TW-1:0] lim_wr_data,
  input  logic          res_valid,
  input  logic          res_chan,
  input  logic [TW-1:0] res_data,
  input  logic          conv_start,
  input  logic          diode_open,
  input  logic          busy,
  input  logic          bus_stop,
  input  logic          bus_clk_edge,
  input  logic          stat_rd,
  output logic [7:0]    stat_data,
  input  logic          alert_clr,
  output logic          alert_n
);
  import tstat_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_i;
  logic [NFLAG-1:0] hit;
  logic             new_flag;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  tstat_limits #(.TW(TW)) u_limits (
    .clk(clk), .rst_n(rst_i), .wr_en(lim_wr_en), .wr_sel(lim_wr_sel),
    .wr_data(lim_wr_data), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .hit(hit)
  );

  tstat_flags u_flags (
    .clk(clk), .rst_n(rst_i), .hit(hit), .res_valid(res_valid),
    .conv_start(conv_start), .diode_open(diode_open), .busy(busy),
    .bus_stop(bus_stop), .bus_clk_edge(bus_clk_edge), .rd_en(stat_rd),
    .rd_data(stat_data), .new_flag(new_flag)
  );

  tstat_alert u_alert (
    .clk(clk), .rst_n(rst_i), .set_i(new_flag), .clr_i(alert_clr),
    .alert_n(alert_n)
  );

  p_busy_bit_r10: assert property (@(posedge clk) disable iff (!rst_i)
    stat_rd |=> (stat_data[7] == $past(busy)));
endmodule

// File: tb/temp_limit_status_tb_top.sv
module temp_limit_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lim_wr_en, res_valid, res_chan, conv_start, diode_open, busy;
  logic       bus_stop, bus_clk_edge, stat_rd, alert_clr;
  logic [1:0] lim_wr_sel;
  logic [7:0] lim_wr_data, res_data, stat_data;
  logic       alert_n;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  temp_limit_status dut_i (
    .clk(clk), .rst_n(rst_n), .lim_wr_en(lim_wr_en), .lim_wr_sel(lim_wr_sel),
    .lim_wr_data(lim_wr_data), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .conv_start(conv_start), .diode_open(diode_open),
    .busy(busy), .bus_stop(bus_stop), .bus_clk_edge(bus_clk_edge),
    .stat_rd(stat_rd), .stat_data(stat_data), .alert_clr(alert_clr),
    .alert_n(alert_n)
  );

  // {chan, result, expected status}; limits LH=30 LL=10 RH=60 RL=-20
  localparam logic [16:0] VEC [0:9] = '{
    {1'b0, 8'd20,  8'h00}, {1'b0, 8'd31,  8'h40}, {1'b0, 8'd30,  8'h00},
    {1'b0, 8'd9,   8'h20}, {1'b0, 8'hFB,  8'h20}, {1'b1, 8'd61,  8'h10},
    {1'b1, 8'hEB,  8'h08}, {1'b1, 8'hEC,  8'h00}, {1'b1, 8'd127, 8'h10},
    {1'b0, 8'h80,  8'h20}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_lim(input logic [1:0] sel, input logic [7:0] val);
    lim_wr_en = 1'b1; lim_wr_sel = sel; lim_wr_data = val;
    tick();
    lim_wr_en = 1'b0;
  endtask

  task automatic result(input logic ch, input logic [7:0] val);
    res_valid = 1'b1; res_chan = ch; res_data = val;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic commit();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    bus_clk_edge = 1'b1; tick(); bus_clk_edge = 1'b0;
  endtask

  task automatic rd();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic aclr();
    alert_clr = 1'b1; tick(); alert_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lim_wr_en = 0; lim_wr_sel = 0; lim_wr_data = 0;
    res_valid = 0; res_chan = 0; res_data = 0; conv_start = 0; diode_open = 0;
    busy = 0; bus_stop = 0; bus_clk_edge = 0; stat_rd = 0; alert_clr = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R2 reset state and extreme default limits
    chk("R2 alert", {7'd0, alert_n}, 8'h01);
    chk("R2 data", stat_data, 8'h00);
    result(1'b0, 8'd127);
    result(1'b1, 8'h80);
    chk("R2 alert after extremes", {7'd0, alert_n}, 8'h01);
    commit(); rd();
    chk("R2 status", stat_data, 8'h00);

    wr_lim(2'd0, 8'd30); wr_lim(2'd1, 8'd10);
    wr_lim(2'd2, 8'd60); wr_lim(2'd3, 8'hEC);

    // R1 / R8 table
    for (int i = 0; i < 10; i++) begin
      result(VEC[i][16], VEC[i][15:8]);
      chk("R8 alert set", {7'd0, alert_n}, (VEC[i][7:0] != 8'h00) ? 8'h00 : 8'h01);
      commit(); rd();
      chk("R1 compare", stat_data, VEC[i][7:0]);
      aclr();
      chk("R8 alert clear", {7'd0, alert_n}, 8'h01);
    end

    // R7 overlapping limits
    wr_lim(2'd0, 8'd10); wr_lim(2'd1, 8'd12);
    result(1'b0, 8'd11);
    commit(); rd();
    chk("R7 both flags", stat_data, 8'h60);
    aclr();
    wr_lim(2'd0, 8'd30); wr_lim(2'd1, 8'd10);

    // R4 reload only after stop then bus edge
    result(1'b0, 8'd40);
    rd();
    chk("R4 before stop", stat_data, 8'h00);
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    rd();
    chk("R4 stop without edge", stat_data, 8'h00);
    bus_clk_edge = 1'b1; tick(); bus_clk_edge = 1'b0;
    rd();
    chk("R4 after edge", stat_data, 8'h40);
    rd();
    chk("R3 cleared by read", stat_data, 8'h00);
    aclr();

    // R3 sticky through an in-range result
    result(1'b0, 8'd40);
    result(1'b0, 8'd20);
    commit(); rd();
    chk("R3 sticky", stat_data, 8'h40);
    commit(); rd();
    chk("R3 cleared", stat_data, 8'h00);
    aclr();

    // R5 collision with a result
    res_valid = 1'b1; res_chan = 1'b1; res_data = 8'd70; stat_rd = 1'b1;
    tick();
    res_valid = 1'b0; stat_rd = 1'b0;
    chk("R5 marker", stat_data, 8'h7F);
    commit(); rd();
    chk("R5 nothing lost", stat_data, 8'h10);
    aclr();

    // R9 collided read with reload does not touch alert
    result(1'b0, 8'd40);
    aclr();
    bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    bus_clk_edge = 1'b1; stat_rd = 1'b1; tick();
    bus_clk_edge = 1'b0; stat_rd = 1'b0;
    chk("R5 marker on reload", stat_data, 8'h7F);
    chk("R9 alert after collided read", {7'd0, alert_n}, 8'h01);
    rd();
    chk("R4 reloaded flag", stat_data, 8'h40);
    chk("R9 alert after read", {7'd0, alert_n}, 8'h01);

    // R10 busy bit and hold
    busy = 1'b1; rd();
    chk("R10 busy", stat_data, 8'h80);
    conv_start = 1'b1; stat_rd = 1'b1; tick();
    conv_start = 1'b0; stat_rd = 1'b0; busy = 1'b0;
    chk("R10 busy marker", stat_data, 8'hFF);
    repeat (3) tick();
    chk("R10 hold", stat_data, 8'hFF);

    // R6 open diode sampled at conversion start only
    diode_open = 1'b1; tick(); rd();
    chk("R6 no start", stat_data, 8'h00);
    conv_start = 1'b1; tick(); conv_start = 1'b0; diode_open = 1'b0;
    rd();
    chk("R6 captured", stat_data, 8'h04);
    rd();
    chk("R6 not cleared by read", stat_data, 8'h04);
    conv_start = 1'b1; tick(); conv_start = 1'b0;
    rd();
    chk("R6 recaptured", stat_data, 8'h00);

    // R8 set wins over clear
    res_valid = 1'b1; res_chan = 1'b0; res_data = 8'd40; alert_clr = 1'b1;
    tick();
    res_valid = 1'b0; alert_clr = 1'b0;
    chk("R8 set priority", {7'd0, alert_n}, 8'h00);
    aclr();
    chk("R8 released", {7'd0, alert_n}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule